// File: doc/BRIEF.md
# Branch and Overflow Redirect Controller

This block decides, every cycle, where a five-stage pipeline fetches next and which pipeline registers receive a bubble. The pipeline fetches sequentially on the assumption that branches fall through. Branches are resolved in the decode stage. When a branch there turns out taken, only the single instruction fetched behind it has to be discarded, so a taken branch costs one cycle.

An arithmetic overflow reported by the execute stage works as a precise exception. The faulting instruction becomes a bubble so it writes no result. The two younger instructions in fetch and decode are discarded. The fetch address is steered to a fixed handler entry. On the same clock edge the block stores the faulting instruction's address plus four into an exception-return register and stores an overflow cause code in a cause register.

The flush outputs are meant to drive the bubble-insert controls of the IF/ID, ID/EX and EX/MEM pipeline registers. `pc_sel` and `redirect_pc` drive the PC multiplexer.

Top module: `redirect_ctl`

## Requirements
- R1: With `br_taken` and `ovf_ex` both low, `pc_sel` is 0 (sequential), `redirect_pc` is 0 and `flush_vec` is 3'b000.
- R2: With `br_taken` high and `ovf_ex` low, `pc_sel` is 1 (branch), `redirect_pc` equals `br_target` and `flush_vec` is 3'b001. Bit 0 is IF/ID, bit 1 is ID/EX and bit 2 is EX/MEM, so only the IF/ID register gets a bubble.
- R3: With `ovf_ex` high, `flush_vec` is 3'b111. This turns the fetch, decode and faulting execute instructions into bubbles.
- R4: With `ovf_ex` high, `pc_sel` is 2 (handler) and `redirect_pc` equals the parameter HANDLER_ADDR, whose default is 32'h8000_0180.
- R5: After a clock edge at which `ovf_ex` was high, `epc_q` holds that cycle's `pc_ex` plus 4, and `cause_q` holds 12.
- R6: When `br_taken` and `ovf_ex` are high in the same cycle, the overflow wins: `pc_sel` is 2, `redirect_pc` is the handler address and `flush_vec` is 3'b111.
- R7: `epc_q` and `cause_q` keep their values across every clock edge at which `ovf_ex` is low, including edges at which a branch is taken.
- R8: A synchronous active-high `rst` clears `epc_q` and `cause_q` to 0.
- R9: The return-address addition wraps modulo 2^32, so `pc_ex` = 32'hFFFF_FFFC stores 0 into `epc_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| br_taken | input | 1 | Branch in decode resolved taken |
| br_target | input | 32 | Target of the decode-stage branch |
| ovf_ex | input | 1 | Overflow detected in execute |
| pc_ex | input | 32 | Address of the instruction in execute |
| flush_vec | output | 3 | Bubble controls: bit0 IF/ID, bit1 ID/EX, bit2 EX/MEM |
| pc_sel | output | 2 | 0 sequential, 1 branch target, 2 handler |
| redirect_pc | output | 32 | Address to load when pc_sel is not 0 |
| epc_q | output | 32 | Saved return address |
| cause_q | output | 5 | Saved exception cause code |

## Verification
The hardest case to reach is an overflow arriving in the same cycle as a taken branch in decode, followed by cycles in which only branches occur. That sequence shows that priority holds and that the exception registers are not disturbed by the later branch traffic. The stimulus drives both inputs together for one cycle with distinct addresses. It then raises branches alone with new `pc_ex` values and confirms that the saved return address still comes from the overflowing cycle. Separate scenarios cover the wrap of the return address at the top of the address space.

// File: rtl/redirect_pkg.sv
package redirect_pkg;

    localparam int XLEN      = 32;
    localparam int CAUSE_W   = 5;
    localparam int N_FLUSH   = 3;
    localparam int INSTR_BYTES = 4;

    localparam logic [CAUSE_W-1:0] CAUSE_OVF = CAUSE_W'(12);

    typedef enum logic [1:0] {
        SEL_SEQ     = 2'd0,
        SEL_BRANCH  = 2'd1,
        SEL_HANDLER = 2'd2
    } pc_sel_e;

    typedef struct packed {
        logic [XLEN-1:0]    ret_pc;
        logic [CAUSE_W-1:0] code;
    } exc_rec_t;

    function automatic logic [XLEN-1:0] next_seq(input logic [XLEN-1:0] pc);
        return pc + XLEN'(INSTR_BYTES);
    endfunction

endpackage

// File: rtl/redirect_arbiter.sv
module redirect_arbiter
    import redirect_pkg::*;
#(
    parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                br_taken,
    input  logic [XLEN-1:0]     br_target,
    input  logic                ovf_ex,
    output logic [N_FLUSH-1:0]  flush_vec,
    output pc_sel_e             pc_sel,
    output logic [XLEN-1:0]     redirect_pc
);

    // Stage 0 (IF/ID) drops on either event; deeper stages only on overflow.
    for (genvar k = 0; k < N_FLUSH; k++) begin : g_flush
        if (k == 0) begin : g_front
            assign flush_vec[k] = ovf_ex | br_taken;
        end else begin : g_deep
            assign flush_vec[k] = ovf_ex;
        end
    end

    always_comb begin
        pc_sel      = SEL_SEQ;
        redirect_pc = '0;
        if (ovf_ex) begin
            pc_sel      = SEL_HANDLER;
            redirect_pc = HANDLER_ADDR;
        end else if (br_taken) begin
            pc_sel      = SEL_BRANCH;
            redirect_pc = br_target;
        end
    end

    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (!br_taken && !ovf_ex) |-> (flush_vec == '0 && pc_sel == SEL_SEQ));

    p_branch_one_r2: assert property (@(posedge clk) disable iff (rst)
        (br_taken && !ovf_ex) |-> ($countones(flush_vec) == 1 && flush_vec[0]
                                   && redirect_pc == br_target));

    p_ovf_flush_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_ex |-> (&flush_vec));

    p_ovf_prio_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_ex |-> (pc_sel == SEL_HANDLER && redirect_pc == HANDLER_ADDR));

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import redirect_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ovf_ex,
    input  logic [XLEN-1:0] pc_ex,
    output exc_rec_t        rec_q
);

    exc_rec_t rec_d;

    always_comb begin
        rec_d = rec_q;
        if (ovf_ex) begin
            rec_d.ret_pc = next_seq(pc_ex);
            rec_d.code   = CAUSE_OVF;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rec_q <= '0;
        else     rec_q <= rec_d;
    end

    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        ovf_ex |=> (rec_q.ret_pc == $past(pc_ex) + 32'd4 && rec_q.code == 5'd12));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ovf_ex |=> $stable(rec_q));

endmodule

// File: rtl/redirect_ctl.sv
module redirect_ctl
    import redirect_pkg::*;
#(
    parameter logic [31:0] HANDLER_ADDR = 32'h8000_0180
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        br_taken,
    input  logic [31:0] br_target,
    input  logic        ovf_ex,
    input  logic [31:0] pc_ex,
    output logic [2:0]  flush_vec,
    output logic [1:0]  pc_sel,
    output logic [31:0] redirect_pc,
    output logic [31:0] epc_q,
    output logic [4:0]  cause_q
);

    pc_sel_e  sel_w;
    exc_rec_t rec_w;

    redirect_arbiter #(.HANDLER_ADDR(HANDLER_ADDR)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .br_taken   (br_taken),
        .br_target  (br_target),
        .ovf_ex     (ovf_ex),
        .flush_vec  (flush_vec),
        .pc_sel     (sel_w),
        .redirect_pc(redirect_pc)
    );

    exc_state_regs u_exc (
        .clk   (clk),
        .rst   (rst),
        .ovf_ex(ovf_ex),
        .pc_ex (pc_ex),
        .rec_q (rec_w)
    );

    assign pc_sel  = sel_w;
    assign epc_q   = rec_w.ret_pc;
    assign cause_q = rec_w.code;

    p_reset_r8: assert property (@(posedge clk)
        $past(rst) |-> (epc_q == '0 && cause_q == '0));

endmodule

// File: tb/tb_redirect_ctl.sv
module tb_redirect_ctl;

    logic        clk = 1'b0;
    logic        rst;
    logic        br_taken;
    logic [31:0] br_target;
    logic        ovf_ex;
    logic [31:0] pc_ex;
    logic [2:0]  flush_vec;
    logic [1:0]  pc_sel;
    logic [31:0] redirect_pc;
    logic [31:0] epc_q;
    logic [4:0]  cause_q;

    int n_checks = 0;
    int n_errors = 0;
    localparam logic [31:0] HANDLER = 32'h8000_0180;

    always #10 clk = ~clk;

    redirect_ctl dut (
        .clk(clk), .rst(rst), .br_taken(br_taken), .br_target(br_target),
        .ovf_ex(ovf_ex), .pc_ex(pc_ex), .flush_vec(flush_vec), .pc_sel(pc_sel),
        .redirect_pc(redirect_pc), .epc_q(epc_q), .cause_q(cause_q)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // drive just after a rising edge, look at combinational outputs at the falling edge
    task automatic drive(input logic b, input logic [31:0] tgt,
                         input logic o, input logic [31:0] pc);
        @(posedge clk); #1;
        br_taken = b; br_target = tgt; ovf_ex = o; pc_ex = pc;
        @(negedge clk);
    endtask

    task automatic settle_idle();
        drive(1'b0, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic t_reset();
        rst = 1'b1; br_taken = 0; br_target = 0; ovf_ex = 0; pc_ex = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R8", "epc after reset", epc_q, 32'h0);
        check("R8", "cause after reset", {27'h0, cause_q}, 32'h0);
    endtask

    task automatic t_idle();
        drive(1'b0, 32'h1234_5678, 1'b0, 32'h0000_0040);
        check("R1", "flush idle", {29'h0, flush_vec}, 32'h0);
        check("R1", "pc_sel idle", {30'h0, pc_sel}, 32'd0);
        check("R1", "redirect idle", redirect_pc, 32'h0);
    endtask

    task automatic t_branch();
        drive(1'b1, 32'h0000_2000, 1'b0, 32'h0000_0100);
        check("R2", "flush branch", {29'h0, flush_vec}, 32'h1);
        check("R2", "pc_sel branch", {30'h0, pc_sel}, 32'd1);
        check("R2", "redirect branch", redirect_pc, 32'h0000_2000);
        drive(1'b1, 32'hABCD_0010, 1'b0, 32'h0000_0104);
        check("R2", "redirect branch 2", redirect_pc, 32'hABCD_0010);
    endtask

    task automatic t_overflow();
        drive(1'b0, 32'h0, 1'b1, 32'h0040_0020);
        check("R3", "flush overflow", {29'h0, flush_vec}, 32'h7);
        check("R4", "pc_sel overflow", {30'h0, pc_sel}, 32'd2);
        check("R4", "redirect overflow", redirect_pc, HANDLER);
        settle_idle();
        check("R5", "epc capture", epc_q, 32'h0040_0024);
        check("R5", "cause capture", {27'h0, cause_q}, 32'd12);
    endtask

    task automatic t_both_then_hold();
        drive(1'b1, 32'h0000_5550, 1'b1, 32'h0010_0008);
        check("R6", "flush both", {29'h0, flush_vec}, 32'h7);
        check("R6", "pc_sel both", {30'h0, pc_sel}, 32'd2);
        check("R6", "redirect both", redirect_pc, HANDLER);
        drive(1'b1, 32'h0000_7000, 1'b0, 32'h0020_0000);
        check("R6", "epc after both", epc_q, 32'h0010_000C);
        drive(1'b1, 32'h0000_7100, 1'b0, 32'h0030_0000);
        settle_idle();
        check("R7", "epc held over branches", epc_q, 32'h0010_000C);
        check("R7", "cause held", {27'h0, cause_q}, 32'd12);
        repeat (3) settle_idle();
        check("R7", "epc held idle", epc_q, 32'h0010_000C);
    endtask

    task automatic t_wrap();
        drive(1'b0, 32'h0, 1'b1, 32'hFFFF_FFFC);
        settle_idle();
        check("R9", "epc wrap", epc_q, 32'h0);
        check("R9", "cause on wrap", {27'h0, cause_q}, 32'd12);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_idle();
                t_branch();
                t_overflow();
                t_both_then_hold();
                t_wrap();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule